// File: doc/BRIEF.md
# Dual Down-Counter Timer with Interrupt Flags

This peripheral holds two 16-bit down-counters behind a byte-wide register port, plus a flag register and an enable register that together drive one level-sensitive interrupt line. Each counter steps down by one on every clock cycle where the external `tick` strobe is high. The first counter can run as a one-shot or, under a mode bit, reload itself from its latch on every expiry. The second counter is always a one-shot.

Software loads a counter in two steps. The low byte goes to a staging latch, and writing the high byte then commits the whole 16-bit value, restarts the count and acknowledges the counter's flag. Reading the low count byte also acknowledges the flag. The interrupt line is a combinational function of the flag and enable registers, so it follows every flag change with no extra register stage. A third flag records a one-cycle `shift_done` pulse from a neighbouring serial unit.

Register addresses: 0 counter A low, 1 counter A high, 2 counter B low, 3 counter B high, 4 mode, 5 flags, 6 enables.

Top module: `vt_timer`

## Requirements
- R1: After reset, both latches and both counts are 0xFFFF, flags, enables and mode are 0, and `irq` is low.
- R2: A write to address 0 or address 2 stores the byte in bits 7:0 of that counter's latch and leaves the running count unchanged.
- R3: A write to address 1 or address 3 stores the byte in latch bits 15:8, loads the full latch into the count, rearms the counter and clears its flag (bit 6 for counter A, bit 5 for counter B).
- R4: A read of address 0 or address 2 returns count bits 7:0 and clears that counter's flag. A read of address 1 or address 3 returns count bits 15:8 and leaves the flags unchanged.
- R5: When counter B is armed and `tick` is high while its count is 0, flag bit 5 is set, the count wraps to 0xFFFF and the counter disarms. Later wraps set no flag until address 3 is written again.
- R6: With mode bit 0 clear, counter A behaves as a one-shot like counter B, using flag bit 6.
- R7: With mode bit 0 set, counter A reloads its latch on each tick at count 0 and sets flag bit 6 on every such expiry.
- R8: `irq` is high exactly when some flag in bits 2, 5 or 6 is set together with its enable bit. It changes in the same cycle as the register that caused the change.
- R9: A read of address 5 returns the flags in bits 6:0 with `irq` in bit 7. Writing address 5 clears each flag whose data bit is 1.
- R10: A write to address 6 with data bit 7 set sets every enable bit whose data bit is 1. With data bit 7 clear, it clears them. A read returns the enables in bits 6:0 and 0 in bit 7.
- R11: Counts change only on a `tick` cycle or on a high-byte write.
- R12: A one-cycle `shift_done` pulse sets flag bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe. Read side effects occur at the clock edge |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick | input | 1 | Count-enable strobe for both counters |
| shift_done | input | 1 | Event pulse that sets flag bit 2 |
| irq | output | 1 | Level interrupt request |

## Verification
Every write, read side effect, tick or `shift_done` pulse changes a register at the next rising edge. `irq` and `rdata` follow that register combinationally in the same cycle, so each result is due one edge after its stimulus. The bench changes inputs on falling edges and samples 1 ns after a falling edge, which is always half a cycle past the edge that produced the result. A counter loaded with N expires on tick number N+1, and the checks count ticks to that edge.

// File: rtl/vt_pkg.sv
package vt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CNTA_LO = 3'd0,
      RA_CNTA_HI = 3'd1,
      RA_CNTB_LO = 3'd2,
      RA_CNTB_HI = 3'd3,
      RA_MODE    = 3'd4,
      RA_FLAGS   = 3'd5,
      RA_ENAB    = 3'd6
   } vt_addr_e;

   localparam int FB_SHIFT = 2;
   localparam int FB_CNTB  = 5;
   localparam int FB_CNTA  = 6;
   localparam int FB_SUM   = 7;

   localparam logic [BYTE_W-1:0] FLAG_MASK =
      (BYTE_W'(1) << FB_SHIFT) | (BYTE_W'(1) << FB_CNTB) | (BYTE_W'(1) << FB_CNTA);
endpackage

// File: rtl/vt_down_timer.sv
module vt_down_timer #(
   parameter int W        = 16,
   parameter bit HAS_CONT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic [W/2-1:0]   din,
   input  logic             cont,
   output logic [W-1:0]     count,
   output logic [W-1:0]     latch,
   output logic             expire
);
   localparam int HALF = W / 2;

   logic [W-1:0] cnt_q;
   logic [W-1:0] lat_q;
   logic         armed_q;
   logic         at_zero;
   logic         reload_now;

   assign at_zero    = (cnt_q == '0);
   assign reload_now = cont && HAS_CONT;
   assign expire     = tick && at_zero && armed_q && !ld_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         lat_q   <= '1;
         armed_q <= 1'b0;
      end else if (ld_hi) begin
         lat_q[W-1:HALF] <= din;
         cnt_q           <= {din, lat_q[HALF-1:0]};
         armed_q         <= 1'b1;
      end else begin
         if (ld_lo) lat_q[HALF-1:0] <= din;
         if (tick) begin
            if (at_zero && reload_now) cnt_q <= lat_q;
            else                       cnt_q <= cnt_q - 1'b1;
         end
         if (expire && !reload_now) armed_q <= 1'b0;
      end
   end

   assign count = cnt_q;
   assign latch = lat_q;
endmodule

// File: rtl/vt_irq_ctrl.sv
module vt_irq_ctrl
   import vt_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MASK = FLAG_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] set_vec,
   input  logic [BYTE_W-1:0] ack_vec,
   input  logic              woc_wr,
   input  logic              en_wr,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] flags,
   output logic [BYTE_W-1:0] enables,
   output logic              irq
);
   logic [BYTE_W-1:0] flg_q, en_q;
   logic [BYTE_W-1:0] woc_vec;
   logic [BYTE_W-1:0] flg_d, en_d;

   assign woc_vec = woc_wr ? din : '0;

   always_comb begin
      flg_d = ((flg_q & ~ack_vec & ~woc_vec) | set_vec) & MASK;
      en_d  = en_q;
      if (en_wr) begin
         if (din[BYTE_W-1]) en_d = (en_q | din) & MASK;
         else               en_d = en_q & ~din & MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg_q <= '0;
         en_q  <= '0;
      end else begin
         flg_q <= flg_d;
         en_q  <= en_d;
      end
   end

   assign flags   = flg_q;
   assign enables = en_q;
   assign irq     = |(flg_q & en_q & MASK);
endmodule

// File: rtl/vt_timer.sv
module vt_timer
   import vt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rdata,
   input  logic              tick,
   input  logic              shift_done,
   output logic              irq
);
   localparam int NTMR = 2;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("vt_timer: CNT_W must be two bytes wide");
      end
   endgenerate

   logic [CNT_W-1:0] t_cnt [NTMR];
   logic [CNT_W-1:0] t_lat [NTMR];
   logic [NTMR-1:0]  t_exp;
   logic [NTMR-1:0]  t_ldlo, t_ldhi, t_rdlo;
   logic             cont_q;
   logic [BYTE_W-1:0] flags, enables;
   logic [BYTE_W-1:0] set_vec, ack_vec;

   assign t_ldlo[0] = wr_en && (addr == RA_CNTA_LO);
   assign t_ldhi[0] = wr_en && (addr == RA_CNTA_HI);
   assign t_rdlo[0] = rd_en && (addr == RA_CNTA_LO);
   assign t_ldlo[1] = wr_en && (addr == RA_CNTB_LO);
   assign t_ldhi[1] = wr_en && (addr == RA_CNTB_HI);
   assign t_rdlo[1] = rd_en && (addr == RA_CNTB_LO);

   for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      vt_down_timer #(.W(CNT_W), .HAS_CONT(i == 0)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .ld_lo  (t_ldlo[i]),
         .ld_hi  (t_ldhi[i]),
         .din    (wdata),
         .cont   (cont_q),
         .count  (t_cnt[i]),
         .latch  (t_lat[i]),
         .expire (t_exp[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          cont_q <= 1'b0;
      else if (wr_en && addr == RA_MODE)   cont_q <= wdata[0];
   end

   always_comb begin
      set_vec           = '0;
      set_vec[FB_CNTA]  = t_exp[0];
      set_vec[FB_CNTB]  = t_exp[1];
      set_vec[FB_SHIFT] = shift_done;
      ack_vec           = '0;
      ack_vec[FB_CNTA]  = t_ldhi[0] || t_rdlo[0];
      ack_vec[FB_CNTB]  = t_ldhi[1] || t_rdlo[1];
   end

   vt_irq_ctrl #(.MASK(FLAG_MASK)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .ack_vec (ack_vec),
      .woc_wr  (wr_en && addr == RA_FLAGS),
      .en_wr   (wr_en && addr == RA_ENAB),
      .din     (wdata),
      .flags   (flags),
      .enables (enables),
      .irq     (irq)
   );

   always_comb begin
      case (addr)
         RA_CNTA_LO: rdata = t_cnt[0][BYTE_W-1:0];
         RA_CNTA_HI: rdata = t_cnt[0][CNT_W-1:BYTE_W];
         RA_CNTB_LO: rdata = t_cnt[1][BYTE_W-1:0];
         RA_CNTB_HI: rdata = t_cnt[1][CNT_W-1:BYTE_W];
         RA_MODE:    rdata = {{(BYTE_W-1){1'b0}}, cont_q};
         RA_FLAGS:   rdata = {irq, flags[BYTE_W-2:0]};
         RA_ENAB:    rdata = {1'b0, enables[BYTE_W-2:0]};
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/vt_timer_chk.sv
module vt_timer_chk
   import vt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic              tick,
   input logic              irq,
   input logic              cont,
   input logic [15:0]       cnt_a,
   input logic [15:0]       lat_a,
   input logic [15:0]       cnt_b,
   input logic              exp_a,
   input logic              exp_b,
   input logic [BYTE_W-1:0] flags,
   input logic [BYTE_W-1:0] enables
);
   a_r3_hi_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_CNTB_HI) |=> !flags[FB_CNTB]);

   a_r4_lo_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == RA_CNTB_LO && !exp_b) |=> !flags[FB_CNTB]);

   a_r5_wrap_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      exp_b |=> (cnt_b == 16'hFFFF));

   a_r7_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_a && cont) |=> (cnt_a == $past(lat_a)));

   a_r8_irq_on_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[FB_CNTA]) && enables[FB_CNTA]) |-> irq);

   a_r11_idle_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(wr_en && addr == RA_CNTB_HI)) |=> $stable(cnt_b));
endmodule

bind vt_timer vt_timer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .tick    (tick),
   .irq     (irq),
   .cont    (cont_q),
   .cnt_a   (t_cnt[0]),
   .lat_a   (t_lat[0]),
   .cnt_b   (t_cnt[1]),
   .exp_a   (t_exp[0]),
   .exp_b   (t_exp[1]),
   .flags   (flags),
   .enables (enables)
);

// File: tb/sim_vt_timer.sv
`timescale 1ns/1ps
module sim_vt_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       tick = 1'b0;
   logic       shift_done = 1'b0;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   vt_timer u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .tick(tick), .shift_done(shift_done), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
      #1;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 irq", {15'd0, irq}, 16'd0);
      rd(3'd1, d); chk("R1 cntA hi", {8'd0, d}, 16'hFF);
      rd(3'd0, d); chk("R1 cntA lo", {8'd0, d}, 16'hFF);
      rd(3'd3, d); chk("R1 cntB hi", {8'd0, d}, 16'hFF);
      rd(3'd2, d); chk("R1 cntB lo", {8'd0, d}, 16'hFF);
      rd(3'd5, d); chk("R1 flags", {8'd0, d}, 16'h00);
      rd(3'd6, d); chk("R1 enables", {8'd0, d}, 16'h00);
      rd(3'd4, d); chk("R1 mode", {8'd0, d}, 16'h00);
   endtask

   task automatic t_stage_then_commit();
      logic [7:0] d;
      wr(3'd2, 8'h05);
      rd(3'd2, d); chk("R2 lo write keeps count", {8'd0, d}, 16'hFF);
      wr(3'd3, 8'h00);
      rd(3'd3, d); chk("R3 hi write loads hi", {8'd0, d}, 16'h00);
      rd(3'd2, d); chk("R3 hi write loads lo", {8'd0, d}, 16'h05);
      repeat (5) @(negedge clk);
      rd(3'd2, d); chk("R11 no tick no change", {8'd0, d}, 16'h05);
   endtask

   task automatic t_b_expire();
      logic [7:0] d;
      wr(3'd6, 8'hA0);
      rd(3'd6, d); chk("R10 enable set", {8'd0, d}, 16'h20);
      ticks(5);
      rd(3'd5, d); chk("R5 no flag at zero", {8'd0, d}, 16'h00);
      rd(3'd2, d); chk("R5 count at zero", {8'd0, d}, 16'h00);
      ticks(1);
      chk("R8 irq on expiry", {15'd0, irq}, 16'd1);
      rd(3'd5, d); chk("R9 flags with summary", {8'd0, d}, 16'hA0);
      rd(3'd3, d); chk("R5 wrap hi", {8'd0, d}, 16'hFF);
      rd(3'd5, d); chk("R4 hi read keeps flag", {8'd0, d}, 16'hA0);
      rd(3'd2, d); chk("R4 lo read data", {8'd0, d}, 16'hFF);
      chk("R8 irq drops on ack", {15'd0, irq}, 16'd0);
      rd(3'd5, d); chk("R4 lo read clears flag", {8'd0, d}, 16'h00);
      ticks(16);
      rd(3'd5, d); chk("R5 one-shot no refire", {8'd0, d}, 16'h00);
      rd(3'd2, d); chk("R5 keeps counting", {8'd0, d}, 16'hEF);
   endtask

   task automatic t_b_hi_clear();
      logic [7:0] d;
      wr(3'd2, 8'h02);
      wr(3'd3, 8'h00);
      ticks(3);
      chk("R5 flag raises irq", {15'd0, irq}, 16'd1);
      wr(3'd3, 8'h01);
      chk("R3 hi write drops irq", {15'd0, irq}, 16'd0);
      rd(3'd5, d); chk("R3 hi write clears flag", {8'd0, d}, 16'h00);
      rd(3'd3, d); chk("R3 reload hi", {8'd0, d}, 16'h01);
      rd(3'd2, d); chk("R3 reload lo from latch", {8'd0, d}, 16'h02);
   endtask

   task automatic t_a_oneshot();
      logic [7:0] d;
      wr(3'd0, 8'h01);
      wr(3'd1, 8'h00);
      wr(3'd6, 8'hC0);
      ticks(2);
      chk("R6 irq", {15'd0, irq}, 16'd1);
      rd(3'd5, d); chk("R6 flag bit6", {8'd0, d}, 16'hC0);
      rd(3'd1, d); chk("R6 wrap hi", {8'd0, d}, 16'hFF);
      rd(3'd0, d); chk("R6 wrap lo", {8'd0, d}, 16'hFF);
      rd(3'd5, d); chk("R4 A lo read clears", {8'd0, d}, 16'h00);
      ticks(3);
      rd(3'd5, d); chk("R6 no refire", {8'd0, d}, 16'h00);
      rd(3'd0, d); chk("R6 keeps counting", {8'd0, d}, 16'hFC);
   endtask

   task automatic t_a_cont();
      logic [7:0] d;
      wr(3'd4, 8'h01);
      rd(3'd4, d); chk("R7 mode readback", {8'd0, d}, 16'h01);
      wr(3'd0, 8'h02);
      wr(3'd1, 8'h00);
      ticks(3);
      rd(3'd5, d); chk("R7 first expiry", {8'd0, d}, 16'hC0);
      wr(3'd5, 8'h40);
      rd(3'd5, d); chk("R9 write-one clears", {8'd0, d}, 16'h00);
      rd(3'd0, d); chk("R7 reloaded", {8'd0, d}, 16'h02);
      ticks(3);
      rd(3'd5, d); chk("R7 second expiry", {8'd0, d}, 16'hC0);
      rd(3'd0, d); chk("R7 reloaded again", {8'd0, d}, 16'h02);
      rd(3'd5, d); chk("R4 A ack in cont", {8'd0, d}, 16'h00);
      wr(3'd4, 8'h00);
   endtask

   task automatic t_shift_flag();
      logic [7:0] d;
      @(negedge clk); shift_done = 1'b1;
      @(negedge clk); shift_done = 1'b0;
      #1;
      chk("R8 masked flag no irq", {15'd0, irq}, 16'd0);
      rd(3'd5, d); chk("R12 shift flag", {8'd0, d}, 16'h04);
      wr(3'd6, 8'h84);
      chk("R8 enable raises irq", {15'd0, irq}, 16'd1);
      rd(3'd6, d); chk("R10 enable bit2 set", {8'd0, d}, 16'h64);
      wr(3'd6, 8'h04);
      chk("R10 clear drops irq", {15'd0, irq}, 16'd0);
      rd(3'd6, d); chk("R10 enable bit2 cleared", {8'd0, d}, 16'h60);
      wr(3'd5, 8'h04);
      rd(3'd5, d); chk("R9 clear shift flag", {8'd0, d}, 16'h00);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_stage_then_commit();
      t_b_expire();
      t_b_hi_clear();
      t_a_oneshot();
      t_a_cont();
      t_shift_flag();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule